// File: doc/BRIEF.md
# Wrapped-Count Synchronous FIFO

This block is a small first-in first-out buffer of 9-bit words, placed on either the receive or the transmit side of a serial controller. A producer writes words with a push strobe, and a consumer sees the oldest word on a show-ahead output and removes it with a pop strobe. Status comes out as a narrow occupancy field, a full flag and a half-full flag.

The occupancy field is one bit narrower than a count of 0 to 8 would need. It therefore shows the count modulo 8 and reads 0 both when the buffer is empty and when it is full. The full flag is the only way to tell the two apart. A soft clear input empties the buffer in one cycle. If the clear arrives while words are still stored, the block raises a sticky busy error so that software can see that data was thrown away. A push that cannot be stored sets a sticky overflow flag.

Top module: `wrapped_fifo`

## Requirements
- R1: Words leave in the order they were pushed; pop_data shows the oldest stored word, and a pop removes it at the next rising clock edge.
- R2: level equals the number of stored words modulo 8 (3 bits), so it reads 0 when 8 words are stored.
- R3: full is 1 exactly when 8 words are stored.
- R4: half is 1 exactly when at least 4 words are stored.
- R5: A push while full without a pop is dropped and sets the sticky overflow flag; a push while full together with a pop is accepted and occupancy stays at 8.
- R6: A pop while empty leaves the contents and level unchanged, and pop_data reads 0 whenever the buffer is empty.
- R7: A push and a pop in the same cycle leave occupancy unchanged when the buffer is not empty; when it is empty, the push is stored and occupancy becomes 1.
- R8: soft_rst empties the buffer and clears overflow at the next edge, and a push or pop in the same cycle has no effect.
- R9: busy_err is set when soft_rst is sampled with at least one word stored, is not set by soft_rst on an empty buffer, and stays set until rst_n.
- R10: rst_n low at a rising edge empties the buffer and clears overflow and busy_err.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of contents and overflow |
| push | input | 1 | Store push_data this cycle |
| push_data | input | 9 | Word to store |
| pop | input | 1 | Remove the oldest word this cycle |
| pop_data | output | 9 | Oldest stored word, 0 when empty |
| level | output | 3 | Stored word count modulo 8 |
| full | output | 1 | 8 words stored |
| half | output | 1 | At least 4 words stored |
| overflow | output | 1 | Sticky: a push was dropped |
| busy_err | output | 1 | Sticky: soft clear discarded stored words |

## Verification
The hardest state to reach is exactly-full, where level has wrapped to 0 and only the full flag separates it from empty. The stimulus reaches it with eight pushes in a row after a mixed push/pop prefix, so the pointers have already wrapped. From there it tries a push that is dropped, a push combined with a pop, and a soft clear that must raise busy_err. A soft clear that arrives in the same cycle as a push is also driven, to show that clearing takes priority.

// File: rtl/wfifo_pkg.sv
// Shared types for the wrapped-count FIFO.
// Assumes nothing beyond the IEEE 1800-2017 language.
package wfifo_pkg;
    // Operation that actually takes effect in a cycle.
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_PUSH = 2'b01,
        OP_POP  = 2'b10,
        OP_BOTH = 2'b11
    } fifo_op_e;

    // Pack the accepted push/pop strobes into an operation code.
    function automatic fifo_op_e make_op(input logic do_push, input logic do_pop);
        return fifo_op_e'({do_pop, do_push});
    endfunction
endpackage

// File: rtl/wfifo_ctrl.sv
// Pointer and occupancy control for the wrapped-count FIFO.
// Decides which strobes are accepted, advances the read and write pointers,
// and keeps a full-width occupancy count.
// Assumes DEPTH is a power of two, so the pointers wrap naturally.
module wfifo_ctrl #(
    parameter int DEPTH = 8,
    localparam int PTRW = $clog2(DEPTH),
    localparam int CNTW = PTRW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            soft_rst,
    input  logic            push,
    input  logic            pop,
    output logic            wr_en,
    output logic [PTRW-1:0] wr_ptr,
    output logic [PTRW-1:0] rd_ptr,
    output logic [CNTW-1:0] count,
    output logic            drop_evt
);
    import wfifo_pkg::*;

    localparam logic [CNTW-1:0] DEPTH_C = CNTW'(DEPTH);

    logic     do_push;
    logic     do_pop;
    fifo_op_e op;

    // Accept strobes: a clear blocks both, a full buffer accepts a push only with a pop.
    always_comb begin
        do_pop   = pop && (count != '0) && !soft_rst;
        do_push  = push && !soft_rst && ((count != DEPTH_C) || do_pop);
        drop_evt = push && !soft_rst && !do_push;
        wr_en    = do_push;
        op       = make_op(do_push, do_pop);
    end

    // Advance pointers and occupancy, or clear them.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            unique case (op)
                OP_PUSH: begin
                    wr_ptr <= wr_ptr + 1'b1;
                    count  <= count + 1'b1;
                end
                OP_POP: begin
                    rd_ptr <= rd_ptr + 1'b1;
                    count  <= count - 1'b1;
                end
                OP_BOTH: begin
                    wr_ptr <= wr_ptr + 1'b1;
                    rd_ptr <= rd_ptr + 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/wfifo_store.sv
// Word storage for the wrapped-count FIFO.
// One write port, one asynchronous show-ahead read port; the read output
// is forced to zero when the buffer is empty.
// Assumes the controller never writes a slot that has not been read.
module wfifo_store #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 8,
    localparam int PTRW  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTRW-1:0]   wr_ptr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTRW-1:0]   rd_ptr,
    input  logic              non_empty,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Write the accepted word into its slot.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    // Present the oldest word, or zero when nothing is stored.
    always_comb begin
        rd_data = non_empty ? mem[rd_ptr] : '0;
    end
endmodule

// File: rtl/wfifo_status.sv
// Status outputs for the wrapped-count FIFO.
// Derives the narrow occupancy field and the flags from the full count,
// and keeps the sticky overflow and busy-error bits.
// Assumes count never exceeds DEPTH.
module wfifo_status #(
    parameter int DEPTH = 8,
    localparam int LVLW = $clog2(DEPTH),
    localparam int CNTW = LVLW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            soft_rst,
    input  logic [CNTW-1:0] count,
    input  logic            drop_evt,
    output logic [LVLW-1:0] level,
    output logic            full,
    output logic            half,
    output logic            overflow,
    output logic            busy_err
);
    localparam logic [CNTW-1:0] DEPTH_C = CNTW'(DEPTH);
    localparam logic [CNTW-1:0] HALF_C  = CNTW'(DEPTH / 2);

    // Occupancy modulo depth, plus the full and half-full flags.
    always_comb begin
        level = count[LVLW-1:0];
        full  = (count == DEPTH_C);
        half  = (count >= HALF_C);
    end

    // Sticky overflow, cleared by either reset.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            overflow <= 1'b0;
        end else if (drop_evt) begin
            overflow <= 1'b1;
        end
    end

    // Sticky busy error when a clear discards stored words; only rst_n clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_err <= 1'b0;
        end else if (soft_rst && (count != '0)) begin
            busy_err <= 1'b1;
        end
    end
endmodule

// File: rtl/wrapped_fifo.sv
// Top level of the wrapped-count FIFO: 8 x 9-bit by default.
// Connects control, storage and status. All state changes on the rising
// edge; rst_n is synchronous and active low, soft_rst is a synchronous clear.
module wrapped_fifo #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 8,
    localparam int PTRW  = $clog2(DEPTH),
    localparam int CNTW  = PTRW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic [PTRW-1:0]   level,
    output logic              full,
    output logic              half,
    output logic              overflow,
    output logic              busy_err
);
    logic            wr_en;
    logic [PTRW-1:0] wr_ptr;
    logic [PTRW-1:0] rd_ptr;
    logic [CNTW-1:0] count;
    logic            drop_evt;

    wfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .push     (push),
        .pop      (pop),
        .wr_en    (wr_en),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .count    (count),
        .drop_evt (drop_evt)
    );

    wfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .wr_en     (wr_en),
        .wr_ptr    (wr_ptr),
        .wr_data   (push_data),
        .rd_ptr    (rd_ptr),
        .non_empty (count != '0),
        .rd_data   (pop_data)
    );

    wfifo_status #(.DEPTH(DEPTH)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .count    (count),
        .drop_evt (drop_evt),
        .level    (level),
        .full     (full),
        .half     (half),
        .overflow (overflow),
        .busy_err (busy_err)
    );
endmodule

// File: rtl/wrapped_fifo_chk.sv
// Property checker for wrapped_fifo, bound to every instance of it.
// Observes ports only.
module wrapped_fifo_chk #(
    parameter int DATA_W = 9,
    parameter int LVLW   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic              push,
    input logic              pop,
    input logic [DATA_W-1:0] pop_data,
    input logic [LVLW-1:0]   level,
    input logic              full,
    input logic              half,
    input logic              overflow,
    input logic              busy_err
);
    AST_FULL_WRAPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (level == '0));                                              // R2
    AST_FULL_IMPLIES_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> half);                                                       // R4
    AST_OVF_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !soft_rst) |=> overflow);                    // R5
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !soft_rst) |=> overflow);                                // R5
    AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((level == '0) && !full) |-> (pop_data == '0));                       // R6
    AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> ((level == '0) && !full && !overflow));                  // R8
    AST_BUSY_ON_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && (full || (level != '0))) |=> busy_err);                  // R9
    AST_BUSY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_err |=> busy_err);                                               // R9
endmodule

bind wrapped_fifo wrapped_fifo_chk #(.DATA_W(DATA_W), .LVLW(PTRW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .push     (push),
    .pop      (pop),
    .pop_data (pop_data),
    .level    (level),
    .full     (full),
    .half     (half),
    .overflow (overflow),
    .busy_err (busy_err)
);

// File: tb/wrapped_fifo_tb.sv
// Self-checking bench for wrapped_fifo: a vector table walk, then directed cases.
module wrapped_fifo_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic       push = 1'b0;
    logic [8:0] push_data = '0;
    logic       pop = 1'b0;
    logic [8:0] pop_data;
    logic [2:0] level;
    logic       full, half, overflow, busy_err;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    wrapped_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .push(push),
        .push_data(push_data), .pop(pop), .pop_data(pop_data), .level(level),
        .full(full), .half(half), .overflow(overflow), .busy_err(busy_err)
    );

    // Fields: push, pop, data, head before edge, level, full, half, overflow after edge
    localparam int NV = 22;
    localparam logic [25:0] VEC [NV] = '{
        {1'b1, 1'b0, 9'h101, 9'h000, 3'd1, 1'b0, 1'b0, 1'b0},
        {1'b1, 1'b0, 9'h002, 9'h101, 3'd2, 1'b0, 1'b0, 1'b0},
        {1'b1, 1'b0, 9'h003, 9'h101, 3'd3, 1'b0, 1'b0, 1'b0},
        {1'b1, 1'b0, 9'h1FF, 9'h101, 3'd4, 1'b0, 1'b1, 1'b0},
        {1'b1, 1'b1, 9'h005, 9'h101, 3'd4, 1'b0, 1'b1, 1'b0},
        {1'b0, 1'b1, 9'h000, 9'h002, 3'd3, 1'b0, 1'b0, 1'b0},
        {1'b1, 1'b0, 9'h006, 9'h003, 3'd4, 1'b0, 1'b1, 1'b0},
        {1'b1, 1'b0, 9'h007, 9'h003, 3'd5, 1'b0, 1'b1, 1'b0},
        {1'b1, 1'b0, 9'h008, 9'h003, 3'd6, 1'b0, 1'b1, 1'b0},
        {1'b1, 1'b0, 9'h009, 9'h003, 3'd7, 1'b0, 1'b1, 1'b0},
        {1'b1, 1'b0, 9'h00A, 9'h003, 3'd0, 1'b1, 1'b1, 1'b0},
        {1'b1, 1'b0, 9'h0BB, 9'h003, 3'd0, 1'b1, 1'b1, 1'b1},
        {1'b0, 1'b1, 9'h000, 9'h003, 3'd7, 1'b0, 1'b1, 1'b1},
        {1'b0, 1'b1, 9'h000, 9'h1FF, 3'd6, 1'b0, 1'b1, 1'b1},
        {1'b0, 1'b1, 9'h000, 9'h005, 3'd5, 1'b0, 1'b1, 1'b1},
        {1'b0, 1'b1, 9'h000, 9'h006, 3'd4, 1'b0, 1'b1, 1'b1},
        {1'b0, 1'b1, 9'h000, 9'h007, 3'd3, 1'b0, 1'b0, 1'b1},
        {1'b0, 1'b1, 9'h000, 9'h008, 3'd2, 1'b0, 1'b0, 1'b1},
        {1'b0, 1'b1, 9'h000, 9'h009, 3'd1, 1'b0, 1'b0, 1'b1},
        {1'b0, 1'b1, 9'h000, 9'h00A, 3'd0, 1'b0, 1'b0, 1'b1},
        {1'b0, 1'b1, 9'h000, 9'h000, 3'd0, 1'b0, 1'b0, 1'b1},
        {1'b1, 1'b1, 9'h0CC, 9'h000, 3'd1, 1'b0, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Drive inputs on the falling edge, return just after the next rising edge.
    task automatic step(input logic p, input logic q, input logic [8:0] d, input logic s);
        @(negedge clk);
        push = p; pop = q; push_data = d; soft_rst = s;
        @(posedge clk);
        #1;
        push = 1'b0; pop = 1'b0; soft_rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=expired expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        chk("R10", "level", level, 0);
        chk("R10", "full", full, 0);
        chk("R10", "half", half, 0);
        chk("R10", "overflow", overflow, 0);
        chk("R10", "busy_err", busy_err, 0);
        chk("R6", "pop_data empty", pop_data, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: R1 head order, R2 level, R3 full, R4 half, R5/R6/R7 corners
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            push = VEC[i][25]; pop = VEC[i][24]; push_data = VEC[i][23:15];
            #1;
            chk("R1", $sformatf("vec%0d head", i), pop_data, VEC[i][14:6]);
            @(posedge clk);
            #1;
            chk("R2", $sformatf("vec%0d level", i), level, VEC[i][5:3]);
            chk("R3", $sformatf("vec%0d full", i), full, VEC[i][2]);
            chk("R4", $sformatf("vec%0d half", i), half, VEC[i][1]);
            chk("R5", $sformatf("vec%0d overflow", i), overflow, VEC[i][0]);
        end
        push = 1'b0; pop = 1'b0;

        // R8/R9: clear with a push in the same cycle and one word stored
        step(1'b1, 1'b0, 9'h155, 1'b1);
        chk("R8", "level after clear", level, 0);
        chk("R8", "full after clear", full, 0);
        chk("R8", "overflow after clear", overflow, 0);
        chk("R8", "pop_data after clear", pop_data, 0);
        chk("R9", "busy set by discard", busy_err, 1);
        step(1'b0, 1'b0, 9'h000, 1'b1);
        chk("R9", "busy sticky", busy_err, 1);

        // R10: rst_n clears busy
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R10", "busy after reset", busy_err, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: clear on empty does not raise busy
        step(1'b0, 1'b0, 9'h000, 1'b1);
        chk("R9", "busy on empty clear", busy_err, 0);

        // Fill to exactly full after a pointer offset
        step(1'b1, 1'b0, 9'h0F0, 1'b0);
        step(1'b0, 1'b1, 9'h000, 1'b0);
        for (int k = 0; k < 8; k++) step(1'b1, 1'b0, 9'(9'h010 + k), 1'b0);
        chk("R2", "level wraps at full", level, 0);
        chk("R3", "full at 8", full, 1);
        // R5: push with pop while full is accepted
        @(negedge clk);
        push = 1'b1; pop = 1'b1; push_data = 9'h1AA;
        #1;
        chk("R1", "head while full", pop_data, 9'h010);
        @(posedge clk);
        #1;
        push = 1'b0; pop = 1'b0;
        chk("R5", "full kept on push+pop", full, 1);
        chk("R5", "no overflow on push+pop", overflow, 0);
        chk("R1", "next head", pop_data, 9'h011);
        // R6: drain all, last word is the one accepted while full
        for (int k = 0; k < 7; k++) step(1'b0, 1'b1, 9'h000, 1'b0);
        chk("R1", "word pushed while full", pop_data, 9'h1AA);
        chk("R2", "level one left", level, 1);
        step(1'b0, 1'b1, 9'h000, 1'b0);
        step(1'b0, 1'b1, 9'h000, 1'b0);
        chk("R6", "level after empty pop", level, 0);
        chk("R6", "full after empty pop", full, 0);
        chk("R6", "pop_data after empty pop", pop_data, 0);

        // R9/R3: clear while full raises busy
        for (int k = 0; k < 8; k++) step(1'b1, 1'b0, 9'(9'h020 + k), 1'b0);
        chk("R3", "full again", full, 1);
        step(1'b0, 1'b0, 9'h000, 1'b1);
        chk("R9", "busy on full clear", busy_err, 1);
        chk("R3", "full cleared", full, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule